// File: doc/BRIEF.md
# Sample-Fetch DMA Stall Timer

This block decides how many processor cycles a sample-channel DMA fetch holds the processor stalled, and then counts that window down. The window length depends on what the bus is doing when the fetch request arrives. Sprite DMA may be in flight, in which case the bytes it still has to move matter. The processor may be in a write cycle, in which case the target address matters. The bus may also be quiet.

A request is only taken while the block is idle and on a processor cycle strobe. The block then raises `stall` for the chosen number of strobed cycles. On the clock after the count reaches zero it drops `stall` and gives a single-clock `done` pulse, which the audio channel uses to load its sample buffer. The memory fetch and the audio channel sit outside this block.

The controller has three named states. `ST_IDLE` waits for a request. `ST_STALL` counts strobes down. `ST_DONE` lasts one clock and produces the pulse. The named transitions are:
- accept: `ST_IDLE` to `ST_STALL` on a strobed request.
- expire: `ST_STALL` to `ST_DONE` on the strobe that takes the count to zero.
- release: `ST_DONE` to `ST_IDLE` on the next clock.

Top module: `dma_stall_arb`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `stall` and `done` are both 0.
- R2: A request with `spr_busy`=0 and `cpu_wr`=0 keeps `stall` high for 4 strobed cycles.
- R3: A request with `spr_busy`=0, `cpu_wr`=1 and `wr_addr`=16'h4014 gives a stall of 2 cycles.
- R4: A request with `spr_busy`=0, `cpu_wr`=1 and any other `wr_addr` gives a stall of 3 cycles.
- R5: A request with `spr_busy`=1 and `spr_left`=2 gives a stall of 1 cycle.
- R6: A request with `spr_busy`=1 and `spr_left`=1 gives a stall of 3 cycles.
- R7: A request with `spr_busy`=1 and any other `spr_left` gives a stall of 2 cycles, whatever `cpu_wr` and `wr_addr` hold; sprite DMA takes priority over the write cases.
- R8: A request is accepted, and the count steps down, only on clocks with `cyc_en`=1. Clocks with `cyc_en`=0 lengthen the stall in clocks, and a request on such a clock is ignored.
- R9: `done` is high for exactly one clock, on the clock right after the last `stall` clock, with `stall` low.
- R10: A request that arrives while `stall` or `done` is high is ignored and does not change the current stall length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Processor cycle strobe |
| req | input | 1 | Sample fetch request |
| spr_busy | input | 1 | Sprite DMA in progress |
| spr_left | input | REM_W (9) | Sprite DMA bytes still to move |
| cpu_wr | input | 1 | Processor write cycle in progress |
| wr_addr | input | ADDR_W (16) | Address of the current processor write |
| stall | output | 1 | Processor is held by the sample fetch |
| done | output | 1 | One-clock pulse that loads the sample buffer |

## Verification
A wrong context decode or a mis-loaded counter shows up directly as a stall run of the wrong length. That is visible at the `stall` port within at most four strobed cycles of the request. A counter that steps on unstrobed clocks shortens a stall measured in clocks once strobe gaps are present. A state machine that lingers in, or skips, the pulse state shows as `done` lasting two clocks or never appearing after `stall` falls. A controller that accepts requests while busy shows as a stretched run or as a second stall right after `done`.

// File: rtl/dma_stall_pkg.sv
package dma_stall_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_DONE  = 2'd2
    } stall_state_e;

    typedef enum logic [2:0] {
        CTX_QUIET    = 3'd0,
        CTX_WR_TRIG  = 3'd1,
        CTX_WR_OTHER = 3'd2,
        CTX_SPR_TWO  = 3'd3,
        CTX_SPR_ONE  = 3'd4,
        CTX_SPR_MID  = 3'd5
    } bus_ctx_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dma_stall_ctx.sv
module dma_stall_ctx
    import dma_stall_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          REM_W     = 9,
    parameter logic [15:0] TRIG_ADDR = 16'h4014
) (
    input  logic              spr_busy,
    input  logic [REM_W-1:0]  spr_left,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    output bus_ctx_e          ctx
);

    localparam logic [REM_W-1:0]  REM_ONE  = REM_W'(1);
    localparam logic [REM_W-1:0]  REM_TWO  = REM_W'(2);
    localparam logic [ADDR_W-1:0] TRIG_CMP = ADDR_W'(TRIG_ADDR);

    // Sprite DMA outranks the processor write cases.
    always_comb begin
        if (spr_busy) begin
            if (spr_left == REM_TWO)      ctx = CTX_SPR_TWO;
            else if (spr_left == REM_ONE) ctx = CTX_SPR_ONE;
            else                          ctx = CTX_SPR_MID;
        end else if (cpu_wr) begin
            if (wr_addr == TRIG_CMP)      ctx = CTX_WR_TRIG;
            else                          ctx = CTX_WR_OTHER;
        end else begin
            ctx = CTX_QUIET;
        end
    end

endmodule

// File: rtl/dma_stall_len.sv
module dma_stall_len
    import dma_stall_pkg::*;
#(
    parameter int CNT_W        = 3,
    parameter int LEN_QUIET    = 4,
    parameter int LEN_WR_TRIG  = 2,
    parameter int LEN_WR_OTHER = 3,
    parameter int LEN_SPR_TWO  = 1,
    parameter int LEN_SPR_ONE  = 3,
    parameter int LEN_SPR_MID  = 2
) (
    input  bus_ctx_e         ctx,
    output logic [CNT_W-1:0] len
);

    always_comb begin
        unique case (ctx)
            CTX_QUIET:    len = CNT_W'(LEN_QUIET);
            CTX_WR_TRIG:  len = CNT_W'(LEN_WR_TRIG);
            CTX_WR_OTHER: len = CNT_W'(LEN_WR_OTHER);
            CTX_SPR_TWO:  len = CNT_W'(LEN_SPR_TWO);
            CTX_SPR_ONE:  len = CNT_W'(LEN_SPR_ONE);
            CTX_SPR_MID:  len = CNT_W'(LEN_SPR_MID);
            default:      len = CNT_W'(LEN_QUIET);
        endcase
    end

endmodule

// File: rtl/dma_stall_fsm.sv
module dma_stall_fsm
    import dma_stall_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             req,
    input  logic [CNT_W-1:0] len,
    output logic             stall,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_IDLE = '0;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    stall_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && cyc_en) begin            // accept
                    state_d = ST_STALL;
                    cnt_d   = len;
                end
            end
            ST_STALL: begin
                if (cyc_en) begin
                    cnt_d = cnt_q - CNT_LAST;
                    if (cnt_q == CNT_LAST) begin    // expire
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE: begin                          // release
                state_d = ST_IDLE;
                cnt_d   = CNT_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = CNT_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_IDLE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        stall = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_STALL: stall = 1'b1;
            ST_DONE:  done  = 1'b1;
            default:  ;
        endcase
    end

    // R8: without a strobe the count holds
    p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && !cyc_en) |=> (cnt_q == $past(cnt_q)));

    // R8: each strobe in the stall takes exactly one off the count
    p_step_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && cyc_en && cnt_q > CNT_LAST) |=>
            (state_q == ST_STALL && cnt_q == $past(cnt_q) - CNT_LAST));

    // R10: a busy controller does not reload on a request
    p_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && req) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dma_stall_arb.sv
module dma_stall_arb
    import dma_stall_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          REM_W        = 9,
    parameter logic [15:0] TRIG_ADDR    = 16'h4014,
    parameter int          LEN_QUIET    = 4,
    parameter int          LEN_WR_TRIG  = 2,
    parameter int          LEN_WR_OTHER = 3,
    parameter int          LEN_SPR_TWO  = 1,
    parameter int          LEN_SPR_ONE  = 3,
    parameter int          LEN_SPR_MID  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              req,
    input  logic              spr_busy,
    input  logic [REM_W-1:0]  spr_left,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              stall,
    output logic              done
);

    localparam int MAX_LEN = max2(max2(max2(LEN_QUIET, LEN_WR_TRIG), max2(LEN_WR_OTHER, LEN_SPR_TWO)),
                                  max2(LEN_SPR_ONE, LEN_SPR_MID));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    bus_ctx_e         ctx;
    logic [CNT_W-1:0] len;

    dma_stall_ctx #(
        .ADDR_W   (ADDR_W),
        .REM_W    (REM_W),
        .TRIG_ADDR(TRIG_ADDR)
    ) u_ctx (
        .spr_busy (spr_busy),
        .spr_left (spr_left),
        .cpu_wr   (cpu_wr),
        .wr_addr  (wr_addr),
        .ctx      (ctx)
    );

    dma_stall_len #(
        .CNT_W       (CNT_W),
        .LEN_QUIET   (LEN_QUIET),
        .LEN_WR_TRIG (LEN_WR_TRIG),
        .LEN_WR_OTHER(LEN_WR_OTHER),
        .LEN_SPR_TWO (LEN_SPR_TWO),
        .LEN_SPR_ONE (LEN_SPR_ONE),
        .LEN_SPR_MID (LEN_SPR_MID)
    ) u_len (
        .ctx (ctx),
        .len (len)
    );

    dma_stall_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en),
        .req    (req),
        .len    (len),
        .stall  (stall),
        .done   (done)
    );

    // R9: the pulse is one clock wide
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the pulse follows a stall clock and never overlaps it
    p_done_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!stall && $past(stall)));

    // R8: a stall only starts from a strobed request
    p_start_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(req && cyc_en));

    // R1: outputs are never both high
    p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

endmodule

// File: tb/dma_stall_arb_tb.sv
module dma_stall_arb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b1;
    logic        req = 1'b0;
    logic        spr_busy = 1'b0;
    logic [8:0]  spr_left = '0;
    logic        cpu_wr = 1'b0;
    logic [15:0] wr_addr = '0;
    logic        stall, done;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    string tag_q[$];
    int run_len = 0;
    logic prev_done = 1'b0;
    logic mon_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dma_stall_arb u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .req(req),
        .spr_busy(spr_busy), .spr_left(spr_left), .cpu_wr(cpu_wr),
        .wr_addr(wr_addr), .stall(stall), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Monitor: measures stall runs and compares them with the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_done && done) check("R9 done width", 2, 1);
            if (stall) begin
                run_len++;
            end else if (done) begin
                check("R9 stall low with done", int'(stall), 0);
                if (exp_q.size() == 0) begin
                    check("R10 unexpected stall", run_len, 0);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, run_len, e);
                end
                run_len = 0;
            end
            prev_done = done;
        end
    end

    task automatic setup(input logic sb, input int left, input logic wr, input logic [15:0] a);
        spr_busy = sb;
        spr_left = 9'(left);
        cpu_wr   = wr;
        wr_addr  = a;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: pushes the expected run length, then issues the request
    task automatic issue(input logic sb, input int left, input logic wr,
                         input logic [15:0] a, input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        setup(sb, left, wr, a);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        setup(1'b0, 0, 1'b0, 16'h0000);
        wait_done();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 stall in reset", int'(stall), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 stall after reset", int'(stall), 0);
        check("R1 done after reset", int'(done), 0);
        mon_on = 1'b1;

        issue(1'b0, 0,   1'b0, 16'h0000, 4, "R2 quiet bus");
        issue(1'b0, 0,   1'b1, 16'h4014, 2, "R3 write to trigger address");
        issue(1'b0, 0,   1'b1, 16'h4015, 3, "R4 write elsewhere");
        issue(1'b0, 0,   1'b1, 16'h2004, 3, "R4 write elsewhere b");
        issue(1'b1, 2,   1'b0, 16'h0000, 1, "R5 two bytes left");
        issue(1'b1, 1,   1'b0, 16'h0000, 3, "R6 one byte left");
        issue(1'b1, 200, 1'b0, 16'h0000, 2, "R7 many bytes left");
        issue(1'b1, 0,   1'b0, 16'h0000, 2, "R7 zero bytes left");
        issue(1'b1, 5,   1'b1, 16'h4014, 2, "R7 priority over trigger write");
        issue(1'b1, 256, 1'b1, 16'h1234, 2, "R7 priority over other write");

        // R8: a request without a strobe is ignored
        @(negedge clk);
        cyc_en = 1'b0;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        cyc_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R8 unstrobed request ignored", int'(stall), 0);
        end

        // R8: strobe on every other clock doubles a 4-cycle stall to 8 clocks
        exp_q.push_back(8);
        tag_q.push_back("R8 strobe gaps");
        @(negedge clk);
        req = 1'b1;
        cyc_en = 1'b1;
        @(negedge clk);
        req = 1'b0;
        cyc_en = 1'b0;
        repeat (3) begin
            @(negedge clk);
            cyc_en = 1'b1;
            @(negedge clk);
            cyc_en = 1'b0;
        end
        @(negedge clk);
        cyc_en = 1'b1;
        wait_done();

        // R10: requests during the stall and during done are ignored
        exp_q.push_back(4);
        tag_q.push_back("R10 request while stalled");
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        setup(1'b1, 2, 1'b0, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        setup(1'b0, 0, 1'b0, 16'h0000);
        while (!done) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R10 request during done ignored", int'(stall), 0);
        end

        repeat (2) @(negedge clk);
        check("R9 all stalls completed", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule